// File: doc/BRIEF.md
# Double-Buffered Quad Converter Register File

This block is the digital front end of a four-channel, 12-bit parallel-input converter. A host reaches it through a parallel bus made of a 2-bit channel select, a read/write line, an active-low chip select and a 12-bit data path. The data path is split into an input, an output and an output enable so that a bidirectional pad can be built around it. Each channel has two registers. The staging register receives host writes. The output register feeds the converter. The four output registers are brought out as one 48-bit word.

An active-low load strobe works in two ways. When it is held low during a write, the write goes straight through to that channel's output register. When it is pulsed while the chip is deselected, all four staging registers are copied into their output registers at the same moment. An active-low clear forces every register to a reset code set by a parameter, and it overrides all other activity. The whole block runs on one fast clock. The load and clear strobes are asynchronous, so each passes through a two-flop synchronizer before it takes effect.

Top module: `qdac_regfile`

## Requirements
- R1: Channel select value 0, 1, 2 or 3 addresses channel A, B, C or D. Channel k occupies bits [12k+11:12k] of `dac_out`.
- R2: While `cs_n` is high, no staging register is written, `dout_oe` is low and `dout` reads zero.
- R3: With `cs_n` low, `rw` low and the synchronized load strobe high, the selected staging register takes `din` and every output register keeps its value.
- R4: With `cs_n` low, `rw` low and the synchronized load strobe low, both the selected staging register and its output register take `din`.
- R5: With `cs_n` high and the synchronized load strobe low, all four output registers take their staging values in the same clock edge.
- R6: With `cs_n` low and `rw` high, `dout_oe` is high and `dout` shows the selected staging register, while the output registers hold.
- R7: While the synchronized clear is low, every staging and output register is forced to `CLR_CODE` (default 0x800), whatever `cs_n`, `rw` or the load strobe are doing.
- R8: A level change on `ld_n` or `clr_n` acts on the registers at the third rising clock edge after it is set up, because each strobe passes through two synchronizer flops.
- R9: After `rst_n` is released, all eight registers hold `CLR_CODE` and both strobes count as inactive. Codes are straight binary, with bit 11 as the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | 1 = read back, 0 = write |
| ld_n | input | 1 | Active-low load strobe (asynchronous) |
| clr_n | input | 1 | Active-low clear (asynchronous) |
| sel | input | 2 | Channel select |
| din | input | 12 | Write data from the bus |
| dout | output | 12 | Readback data to the bus |
| dout_oe | output | 1 | Bus drive enable, high only during a read |
| dac_out | output | 48 | Four output-register codes, channel A in the low bits |

## Verification
Clear and a transparent write can fall in the same clock edge, because a host can hold chip select, write and load low while the clear strobe arrives. The bench provokes this by starting a transparent write to channel A with a distinctive code and asserting clear before that write ends. The chip is deselected before clear is released. The test passes only if all four outputs read the reset code and the staging register for A reads back the reset code, not the written value. A second overlap occurs when the load strobe is released: its synchronized copy is still low for two edges after chip select has already risen, so a write's trailing edge turns into a transfer of all channels. The vector table expects output values that already include that transfer.

// File: rtl/qdac_regfile.sv
`timescale 1ns/1ps
module qdac_regfile #(
  parameter int W = 12,
  parameter int CH = 4,
  parameter int SW = $clog2(CH),
  parameter logic [W-1:0] CLR_CODE = 12'h800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            rw,
  input  logic            ld_n,
  input  logic            clr_n,
  input  logic [SW-1:0]   sel,
  input  logic [W-1:0]    din,
  output logic [W-1:0]    dout,
  output logic            dout_oe,
  output logic [CH*W-1:0] dac_out
);
  logic [1:0]   ld_q, clr_q;
  logic         ld_s, clr_s, wr;
  logic [W-1:0] in_r  [CH];
  logic [W-1:0] out_r [CH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ld_q  <= 2'b11;
      clr_q <= 2'b11;
    end else begin
      ld_q  <= {ld_q[0], ld_n};
      clr_q <= {clr_q[0], clr_n};
    end

  assign ld_s  = ld_q[1];
  assign clr_s = clr_q[1];
  assign wr    = !cs_n && !rw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < CH; i++) begin
        in_r[i]  <= CLR_CODE;
        out_r[i] <= CLR_CODE;
      end
    end else if (!clr_s) begin
      for (int i = 0; i < CH; i++) begin
        in_r[i]  <= CLR_CODE;
        out_r[i] <= CLR_CODE;
      end
    end else begin
      for (int i = 0; i < CH; i++) begin
        if (wr && sel == SW'(i)) in_r[i] <= din;
        if (wr && !ld_s && sel == SW'(i)) out_r[i] <= din;
        else if (cs_n && !ld_s)           out_r[i] <= in_r[i];
      end
    end

  assign dout_oe = !cs_n && rw;
  assign dout    = dout_oe ? in_r[sel] : '0;

  for (genvar g = 0; g < CH; g++) begin : g_out
    assign dac_out[g*W +: W] = out_r[g];
  end
endmodule

module qdac_regfile_chk #(
  parameter int W = 12,
  parameter int CH = 4,
  parameter int SW = 2,
  parameter logic [W-1:0] CLR_CODE = 12'h800
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            rw,
  input logic            clr_n,
  input logic [SW-1:0]   sel,
  input logic [W-1:0]    din,
  input logic [W-1:0]    dout,
  input logic            dout_oe,
  input logic [CH*W-1:0] dac_out,
  input logic            ld_s,
  input logic            clr_s,
  input logic [W-1:0]    in_r [CH]
);
  logic [CH*W-1:0] in_flat;
  for (genvar g = 0; g < CH; g++) begin : g_flat
    assign in_flat[g*W +: W] = in_r[g];
  end

  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!dout_oe && dout == '0));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_s && clr_s) |=> $stable(dac_out));

  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rw && !ld_s && clr_s) |=> dac_out[$past(sel)*W +: W] == $past(din));

  // R5
  bulk_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !ld_s && clr_s) |=> dac_out == $past(in_flat));

  // R7
  clear_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && $past(!clr_n) && $past(!clr_n, 2)) |=> dac_out == {CH{CLR_CODE}});
endmodule

bind qdac_regfile qdac_regfile_chk #(.W(W), .CH(CH), .SW(SW), .CLR_CODE(CLR_CODE)) chk_i (.*);

// File: tb/qdac_regfile_tb_top.sv
`timescale 1ns/1ps
module qdac_regfile_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        cs_n = 1, rw = 1, ld_n = 1, clr_n = 1;
  logic [1:0]  sel = 0;
  logic [11:0] din = 0;
  logic [11:0] dout;
  logic        dout_oe;
  logic [47:0] dac_out;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  qdac_regfile dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .ld_n(ld_n),
    .clr_n(clr_n), .sel(sel), .din(din), .dout(dout), .dout_oe(dout_oe), .dac_out(dac_out));

  // {cs_n, rw, ld_n, sel, din, expected dac_out after the vector}
  localparam logic [64:0] VEC [10] = '{
    {1'b0,1'b0,1'b1,2'd0,12'h123,48'h800800800800},  // R3 write A
    {1'b0,1'b0,1'b1,2'd1,12'h456,48'h800800800800},  // R3 write B
    {1'b1,1'b1,1'b0,2'd0,12'h000,48'h800800456123},  // R5 transfer all
    {1'b0,1'b0,1'b0,2'd2,12'hABC,48'h800ABC456123},  // R4 transparent C
    {1'b0,1'b0,1'b1,2'd3,12'hFFF,48'h800ABC456123},  // R3 write D
    {1'b0,1'b0,1'b1,2'd0,12'h000,48'h800ABC456123},  // R3 write A
    {1'b1,1'b1,1'b0,2'd0,12'h000,48'hFFFABC456000},  // R5 transfer all
    {1'b0,1'b0,1'b0,2'd3,12'h001,48'h001ABC456000},  // R4 transparent D
    {1'b0,1'b1,1'b1,2'd1,12'h999,48'h001ABC456000},  // R6 read, outputs hold
    {1'b1,1'b0,1'b1,2'd2,12'h777,48'h001ABC456000}   // R2 deselected write
  };

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1; rw = 1; ld_n = 1;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    check("R9 reset outputs", dac_out, 48'h800800800800);
    check("R2 reset bus idle", {47'd0, dout_oe}, 48'd0);

    foreach (VEC[k]) begin
      {cs_n, rw, ld_n, sel, din} = VEC[k][64:48];
      tick(4);
      if (k == 8) check("R6 read B", {35'd0, dout_oe, dout}, {35'd0, 1'b1, 12'h456});
      if (k == 9) check("R2 deselected bus", {35'd0, dout_oe, dout}, 48'd0);
      idle();
      tick(3);
      check($sformatf("R3/R4/R5 vector %0d", k), dac_out, VEC[k][47:0]);
    end

    for (int c = 0; c < 4; c++) begin
      logic [11:0] e;
      e = (c == 0) ? 12'h000 : (c == 1) ? 12'h456 : (c == 2) ? 12'hABC : 12'h001;
      cs_n = 0; rw = 1; sel = 2'(c);
      tick(1);
      check($sformatf("R1 R6 readback ch %0d", c), {35'd0, dout_oe, dout}, {35'd0, 1'b1, e});
    end
    idle();
    tick(1);

    // R8: load strobe latency
    cs_n = 0; rw = 0; sel = 0; din = 12'h777;
    tick(2);
    idle();
    tick(2);
    ld_n = 0;
    tick(2);
    check("R8 no transfer before third edge", dac_out, 48'h001ABC456000);
    tick(1);
    check("R8 transfer on third edge", dac_out, 48'h001ABC456777);
    ld_n = 1;
    tick(3);

    // R7: clear overlapping a transparent write
    cs_n = 0; rw = 0; ld_n = 0; sel = 0; din = 12'h555;
    tick(2);
    clr_n = 0;
    tick(4);
    check("R7 clear beats transparent write", dac_out, 48'h800800800800);
    idle();
    tick(3);
    clr_n = 1;
    tick(4);
    check("R7 outputs after clear", dac_out, 48'h800800800800);
    cs_n = 0; rw = 1; sel = 0;
    tick(1);
    check("R7 staging A cleared", {36'd0, dout}, {36'd0, 12'h800});
    idle();

    // R7: clear with chip deselected
    cs_n = 0; rw = 0; ld_n = 0; sel = 2; din = 12'h3C3;
    tick(4);
    idle();
    tick(3);
    check("R4 write before clear", dac_out, 48'h8003C3800800);
    clr_n = 0;
    tick(2);
    check("R8 clear not yet active", dac_out, 48'h8003C3800800);
    tick(1);
    check("R7 clear while deselected", dac_out, 48'h800800800800);
    clr_n = 1;
    tick(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule